// File: doc/BRIEF.md
# Standby Wake Event Register Unit

This block collects wake events from four sources (two ring-indicate lines, a keyboard line and a mouse line) and keeps them in sticky status bits. Each source arrives as a single-cycle pulse. A global event flag summarises the enabled sources, and an active-low power-management event output is driven from that flag through a global enable. Software reads the state and clears it through an indexed register bus with an address, write data, a write strobe and combinational read data.

The unit lives in the standby power domain. Its only reset is the standby-supply power-on reset, so main-supply power-on, soft reset and hard reset cannot disturb the status it holds. The per-source enable vector and the global enable come in as plain inputs.

The global flag follows the level of "some wake status bit is set while its source is enabled". A write-1 clear of the flag therefore has effect only after the enabled wake bits have been cleared. Until then the flag keeps being set.

Top module: `wake_event_unit`

## Requirements
- R1: While the standby reset is asserted, and right after it is released, both status registers read 0x00 and the event output `pmeOutN` is high.
- R2: A pulse on `wakePulse[k]` sets wake status bit k+1 at the next clock edge, whatever `srcEnable` and `pmeEnable` hold. The bit map is: bit 1 second ring indicate (`wakePulse[0]`), bit 2 first ring indicate (`wakePulse[1]`), bit 3 keyboard (`wakePulse[2]`), bit 4 mouse (`wakePulse[3]`).
- R3: Writing a byte to index 0xC7 clears every wake status bit whose position in the byte holds 1. Bits written as 0 are left unchanged.
- R4: If a wake pulse and a write-1 clear hit the same wake status bit in the same cycle, the bit stays set.
- R5: The global flag (bit 0 at index 0xC6) becomes 1 at the clock edge that follows any cycle in which a wake status bit and its `srcEnable` bit are both 1. This happens regardless of `pmeEnable`, and it also happens when a clear of the flag is written in that same cycle.
- R6: Writing 1 to bit 0 at index 0xC6 clears the global flag when no enabled wake status bit is set. Writing 0 to that bit leaves the flag unchanged.
- R7: `pmeOutN` is low exactly while the global flag is 1 and `pmeEnable` is 1, and it is high otherwise.
- R8: The reserved bits read as 0: bits 7:1 at index 0xC6, and bits 0 and 7:5 at index 0xC7. Writes to reserved bits change nothing.
- R9: Reads from any index other than 0xC6 and 0xC7 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| standbyRstN | input | 1 | Active-low standby-supply power-on reset, asynchronous |
| wakePulse | input | 4 | One-cycle wake event pulses: second ring, first ring, keyboard, mouse |
| srcEnable | input | 4 | Per-source enables, same order as wakePulse |
| pmeEnable | input | 1 | Global enable for the event output |
| regAddr | input | 8 | Register index |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Write strobe, one write per cycle |
| regRdData | output | 8 | Combinational read data for regAddr |
| pmeOutN | output | 1 | Active-low power-management event output |

## Verification
The bench sweeps every enable vector against every source with the global enable both off and on. It checks the exact wake bit that gets latched, which catches a bit map shifted by one position or a status bit gated by its enable. It also checks whether the flag and the output follow, which catches an output that ignores the global enable or a flag that needs the global enable before it can set.

Several targeted cases follow the sweep. A clear written in the same cycle as an event must leave the bit set; a clear-first design would lose the event. Clearing the flag while an enabled bit is still set must leave the flag at 1. Written zeros and reserved-bit writes must change nothing, and foreign indices must be ignored; a decoder that matches too widely fails these cases.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic               globalClr;
    logic [NUM_SRC-1:0] wakeClr;
  } ctrl_strobe_t;
endpackage

// File: rtl/pmw_ctrl.sv
module pmw_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] GLOBAL_IDX = 8'hC6,
  parameter logic [ADDR_W-1:0] WAKE_IDX = 8'hC7,
  parameter int WAKE_LSB = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic                        regWrEn,
  input  logic                        globalFlag,
  input  logic [pmw_pkg::NUM_SRC-1:0] wakeStat,
  output pmw_pkg::ctrl_strobe_t       strobes,
  output logic [DATA_W-1:0]           regRdData
);
  localparam int NSRC = pmw_pkg::NUM_SRC;
  localparam int WAKE_MSB = WAKE_LSB + NSRC - 1;

  logic hitGlobal;
  logic hitWake;

  assign hitGlobal = (regAddr == GLOBAL_IDX);
  assign hitWake   = (regAddr == WAKE_IDX);

  // Write decode: only the defined bits become clear strobes.
  always_comb begin
    strobes = '0;
    strobes.globalClr = regWrEn && hitGlobal && regWrData[0];
    if (regWrEn && hitWake) begin
      strobes.wakeClr = regWrData[WAKE_MSB:WAKE_LSB];
    end
  end

  // Read mux: reserved and foreign bits stay at zero.
  always_comb begin
    regRdData = '0;
    if (hitGlobal) begin
      regRdData[0] = globalFlag;
    end else if (hitWake) begin
      regRdData[WAKE_MSB:WAKE_LSB] = wakeStat;
    end
  end

  // R3, R6, R9: no clear strobe without a write to a matching index
  p_no_stray_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn || (!hitGlobal && !hitWake)) |-> (strobes == '0));

  // R8: the reserved low bit of the wake register always reads zero
  p_reserved_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitWake |-> (regRdData[0] == 1'b0));
endmodule

// File: rtl/pmw_datapath.sv
module pmw_datapath (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [pmw_pkg::NUM_SRC-1:0] wakePulse,
  input  logic [pmw_pkg::NUM_SRC-1:0] srcEnable,
  input  logic                        pmeEnable,
  input  pmw_pkg::ctrl_strobe_t       strobes,
  output logic [pmw_pkg::NUM_SRC-1:0] wakeStat,
  output logic                        globalFlag,
  output logic                        pmeOutN
);
  localparam int NSRC = pmw_pkg::NUM_SRC;

  logic anyArmed;

  // One sticky bit per source; the event takes priority over the clear.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wakeStat[i] <= 1'b0;
      end else if (wakePulse[i]) begin
        wakeStat[i] <= 1'b1;
      end else if (strobes.wakeClr[i]) begin
        wakeStat[i] <= 1'b0;
      end
    end

    // R2, R4: an event always leaves its bit set
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
      wakePulse[i] |=> wakeStat[i]);

    // R3: a write-1 clear without a competing event clears the bit
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wakeClr[i] && !wakePulse[i]) |=> !wakeStat[i]);

    // R3: with no event and no clear the bit holds its value
    p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.wakeClr[i] && !wakePulse[i]) |=> $stable(wakeStat[i]));
  end

  assign anyArmed = |(wakeStat & srcEnable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalFlag <= 1'b0;
    end else if (anyArmed) begin
      globalFlag <= 1'b1;
    end else if (strobes.globalClr) begin
      globalFlag <= 1'b0;
    end
  end

  assign pmeOutN = ~(globalFlag & pmeEnable);

  // R5: an enabled pending source sets the flag on the next edge
  p_global_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    anyArmed |=> globalFlag);

  // R6: the flag only falls through a write-1 clear
  p_global_falls_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(globalFlag) |-> $past(strobes.globalClr));
endmodule

// File: rtl/wake_event_unit.sv
module wake_event_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] GLOBAL_IDX = 8'hC6,
  parameter logic [ADDR_W-1:0] WAKE_IDX = 8'hC7,
  parameter int WAKE_LSB = 1
) (
  input  logic                        clk,
  input  logic                        standbyRstN,
  input  logic [pmw_pkg::NUM_SRC-1:0] wakePulse,
  input  logic [pmw_pkg::NUM_SRC-1:0] srcEnable,
  input  logic                        pmeEnable,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic                        regWrEn,
  output logic [DATA_W-1:0]           regRdData,
  output logic                        pmeOutN
);
  pmw_pkg::ctrl_strobe_t       strobes;
  logic [pmw_pkg::NUM_SRC-1:0] wakeStat;
  logic                        globalFlag;

  pmw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLOBAL_IDX(GLOBAL_IDX),
    .WAKE_IDX(WAKE_IDX), .WAKE_LSB(WAKE_LSB)
  ) ctrl_i (
    .clk(clk), .rstN(standbyRstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .globalFlag(globalFlag), .wakeStat(wakeStat),
    .strobes(strobes), .regRdData(regRdData)
  );

  pmw_datapath dp_i (
    .clk(clk), .rstN(standbyRstN), .wakePulse(wakePulse), .srcEnable(srcEnable),
    .pmeEnable(pmeEnable), .strobes(strobes), .wakeStat(wakeStat),
    .globalFlag(globalFlag), .pmeOutN(pmeOutN)
  );

  // R7: the output is never low while the global enable is off
  p_out_gated_r7: assert property (@(posedge clk) disable iff (!standbyRstN)
    !pmeEnable |-> pmeOutN);
endmodule

// File: tb/wake_event_unit_tb.sv
module wake_event_unit_tb_top;
  logic       clk = 1'b0;
  logic       standbyRstN = 1'b0;
  logic [3:0] wakePulse = '0;
  logic [3:0] srcEnable = '0;
  logic       pmeEnable = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       pmeOutN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_event_unit dut_i (
    .clk(clk), .standbyRstN(standbyRstN), .wakePulse(wakePulse),
    .srcEnable(srcEnable), .pmeEnable(pmeEnable), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData),
    .pmeOutN(pmeOutN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [7:0] val);
    regAddr = addr;
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] p);
    @(negedge clk);
    wakePulse = p;
    @(negedge clk);
    wakePulse = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    readReg(8'hC6, v); check("R1 global reset", v, 8'h00);
    readReg(8'hC7, v); check("R1 wake reset", v, 8'h00);
    check("R1 out reset", {7'b0, pmeOutN}, 8'h01);
    @(negedge clk); standbyRstN = 1'b1;
    @(negedge clk);
    readReg(8'hC7, v); check("R1 wake after release", v, 8'h00);

    // Sweep: enables x source x global enable (R2, R5, R6, R7, R3)
    for (int en = 0; en < 16; en++) begin
      for (int s = 0; s < 4; s++) begin
        for (int g = 0; g < 2; g++) begin
          logic armed;
          logic [7:0] bitv;
          armed = en[s];
          bitv = 8'h01 << (s + 1);
          srcEnable = 4'(en); pmeEnable = g[0];
          pulse(4'b0001 << s);
          readReg(8'hC7, v); check("R2 latch bit", v, bitv);
          @(negedge clk);
          readReg(8'hC6, v); check("R5 flag follows enable", v, {7'b0, armed});
          check("R7 output", {7'b0, pmeOutN}, {7'b0, !(armed && g[0])});
          writeReg(8'hC7, 8'h00);
          readReg(8'hC7, v); check("R3 write zero keeps", v, bitv);
          writeReg(8'hC6, 8'h01);
          readReg(8'hC6, v); check("R5 set beats clear", v, {7'b0, armed});
          writeReg(8'hC7, bitv);
          readReg(8'hC7, v); check("R3 write one clears", v, 8'h00);
          writeReg(8'hC6, 8'h00);
          readReg(8'hC6, v); check("R6 write zero keeps flag", v, {7'b0, armed});
          writeReg(8'hC6, 8'h01);
          readReg(8'hC6, v); check("R6 flag cleared", v, 8'h00);
          check("R7 output released", {7'b0, pmeOutN}, 8'h01);
        end
      end
    end

    // R4: event and clear in the same cycle
    srcEnable = '0; pmeEnable = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      wakePulse = 4'b0001 << s;
      regAddr = 8'hC7; regWrData = 8'h1E; regWrEn = 1'b1;
      @(negedge clk);
      wakePulse = '0; regWrEn = 1'b0;
      readReg(8'hC7, v); check("R4 event wins", v, 8'h01 << (s + 1));
      writeReg(8'hC7, 8'h1E);
    end

    // R8: reserved bits of the wake register
    pulse(4'hF);
    writeReg(8'hC7, 8'hE1);
    readReg(8'hC7, v); check("R8 reserved wake write", v, 8'h1E);
    // R9: foreign index
    writeReg(8'hC5, 8'hFF);
    writeReg(8'h47, 8'hFF);
    readReg(8'hC7, v); check("R9 foreign write ignored", v, 8'h1E);
    readReg(8'hC5, v); check("R9 foreign read zero", v, 8'h00);
    // R8: reserved bits of the global register
    srcEnable = 4'h1;
    @(negedge clk); @(negedge clk);
    writeReg(8'hC7, 8'h1E);
    writeReg(8'hC6, 8'hFE);
    readReg(8'hC6, v); check("R8 reserved global write", v, 8'h01);
    // R7: output follows the global enable live
    pmeEnable = 1'b1; #1;
    check("R7 output low", {7'b0, pmeOutN}, 8'h00);
    pmeEnable = 1'b0; #1;
    check("R7 output gated", {7'b0, pmeOutN}, 8'h01);

    // R1: the standby reset clears held state
    pulse(4'h6);
    @(negedge clk); standbyRstN = 1'b0; #1;
    readReg(8'hC7, v); check("R1 wake cleared", v, 8'h00);
    readReg(8'hC6, v); check("R1 flag cleared", v, 8'h00);
    @(negedge clk); standbyRstN = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule